// File: doc/BRIEF.md
# Banked Tile Memory Access Checker

This block sits in front of a banked local SRAM and judges, in one registered stage, every request that reaches it in a cycle. Three requesters may arrive together: an instruction-fetch port and two data ports (A and B). For each one the block works out which region the byte address falls in, which 64-bit bank it needs and which word of that bank. It then raises an exception code for an unpopulated address, a misaligned access, an access type that the region does not allow, or two ports fighting over one bank.

The lower region keeps each 16 KB bank contiguous. The upper region interleaves a pair of banks on address bit 3, so neighbouring 64-bit words alternate between the even and the odd bank and a 128-bit load can take both halves at once. The per-port bank enables and word indices drive the SRAM arrays. Those arrays are outside this block. A port that carries an exception enables no bank.

Top module: `tile_mem_access_chk`

## Requirements
- R1: A valid request whose 21-bit address lies below 0x40000 or above 0x7FFFF gets exception code 1 (unpopulated).
- R2: In the lower region (address bit 17 = 0) the bank enable is one-hot at bank index addr[16:14] (banks 0 to 7) and the word is addr[13:3].
- R3: In the upper region (bit 17 = 1) the bank index is 8 + 2*addr[16:15] + addr[3] and the word is addr[14:4], so consecutive 64-bit words alternate between the even and the odd bank of a pair.
- R4: A data load of size code 4 (128 bits) in the upper region enables both banks 8+2*addr[16:15] and 9+2*addr[16:15]. In the lower region the same load gets code 3 (illegal access type).
- R5: A fetch is always 64 bits wide. It gets code 2 unless addr[2:0] is 0, and code 3 when it targets the upper region.
- R6: Data size codes 0 to 4 mean 8, 16, 32, 64 and 128 bits. An address that is not a multiple of the size gets code 2. Size codes 5 to 7 get code 3.
- R7: A store (write = 1) of any size other than 32 or 64 bits gets code 3. When port A presents a valid store, a store on port B in the same cycle gets code 3.
- R8: When two or more ports that have no other exception need the same bank, every one of them gets code 4 (clash). Ports on different banks are served together.
- R9: Only the highest-priority exception is reported, in the order unpopulated (1), misaligned (2), illegal type (3), clash (4). A port with an earlier exception takes no part in clash detection.
- R10: Outputs are registered and appear one clock after the request. During reset, and for a port that is not valid, enable, word and code are all zero.
- R11: A port that reports any non-zero code drives an all-zero bank enable and word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| if_valid | input | 1 | Fetch request present |
| if_addr | input | 21 | Fetch byte address |
| da_valid | input | 1 | Data port A request present |
| da_addr | input | 21 | Data port A byte address |
| da_size | input | 3 | Data port A size code (0..4 = 8..128 bits) |
| da_wr | input | 1 | Data port A store |
| db_valid | input | 1 | Data port B request present |
| db_addr | input | 21 | Data port B byte address |
| db_size | input | 3 | Data port B size code |
| db_wr | input | 1 | Data port B store |
| if_bank_en | output | 16 | Fetch bank enables |
| if_word | output | 11 | Fetch word index |
| if_exc | output | 3 | Fetch exception code |
| da_bank_en | output | 16 | Data port A bank enables |
| da_word | output | 11 | Data port A word index |
| da_exc | output | 3 | Data port A exception code |
| db_bank_en | output | 16 | Data port B bank enables |
| db_word | output | 11 | Data port B word index |
| db_exc | output | 3 | Data port B exception code |

## Verification
A port's own exception check and the clash check between ports can land in the same cycle. When they do, the port's own exception must win and must also take that port out of the clash. The bench provokes this by driving all three ports at once from a grid of bank choices. The grid mixes clean 64-bit accesses in both regions, 128-bit pair loads, unpopulated, misaligned and illegal-type requests, and store patterns. The bench judges every port against codes that it computes arithmetically from the address, size and write bits. It first evaluates each port on its own and only then intersects the enables of the surviving ports.

// File: rtl/tmac_pkg.sv
package tmac_pkg;
    typedef enum logic [2:0] {
        EXC_NONE   = 3'd0,
        EXC_UNPOP  = 3'd1,
        EXC_ALIGN  = 3'd2,
        EXC_ACCESS = 3'd3,
        EXC_CLASH  = 3'd4
    } exc_e;

    localparam logic [2:0] SZ_8   = 3'd0;
    localparam logic [2:0] SZ_16  = 3'd1;
    localparam logic [2:0] SZ_32  = 3'd2;
    localparam logic [2:0] SZ_64  = 3'd3;
    localparam logic [2:0] SZ_128 = 3'd4;
endpackage

// File: rtl/tmac_decode.sv
module tmac_decode
    import tmac_pkg::*;
#(
    parameter int          ADDR_W     = 21,
    parameter int          REGION_BIT = 17,
    parameter int          BANK_BYTES = 16384,
    parameter int unsigned POP_BASE   = 32'h4_0000,
    parameter int unsigned POP_LAST   = 32'h7_FFFF,
    parameter int          NBANK      = 16,
    parameter int          WORD_W     = 11
) (
    input  logic              valid,
    input  logic              is_fetch,
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        size,
    input  logic              wr,
    input  logic              store_blk,
    output logic [NBANK-1:0]  bank_en,
    output logic [WORD_W-1:0] word,
    output logic [2:0]        exc
);
    localparam int BOFF   = $clog2(BANK_BYTES);
    localparam int BSEL_W = $clog2(NBANK);

    logic [2:0]        eff_size;
    logic              populated;
    logic              misal;
    logic              upper;
    logic              wide;
    logic              bad_type;
    logic [BSEL_W-3:0] elem;

    always_comb begin
        eff_size  = is_fetch ? SZ_64 : size;
        populated = (32'(addr) >= POP_BASE) && (32'(addr) <= POP_LAST);
        case (eff_size)
            SZ_16:   misal = addr[0];
            SZ_32:   misal = |addr[1:0];
            SZ_64:   misal = |addr[2:0];
            SZ_128:  misal = |addr[3:0];
            default: misal = 1'b0;
        endcase
        upper    = addr[REGION_BIT];
        elem     = addr[REGION_BIT-1 -: (BSEL_W-2)];
        wide     = !is_fetch && (size == SZ_128);
        bad_type = is_fetch ? upper
                 : ((size > SZ_128)
                    || (wide && !upper)
                    || (wr && (size != SZ_32) && (size != SZ_64))
                    || (wr && store_blk));

        bank_en = '0;
        word    = '0;
        exc     = EXC_NONE;
        if (valid) begin
            if (!populated) begin
                exc = EXC_UNPOP;
            end else if (misal) begin
                exc = EXC_ALIGN;
            end else if (bad_type) begin
                exc = EXC_ACCESS;
            end else if (!upper) begin
                bank_en[{1'b0, addr[REGION_BIT-1:BOFF]}] = 1'b1;
                word = addr[BOFF-1:3];
            end else begin
                bank_en[{1'b1, elem, addr[3]}] = 1'b1;
                if (wide) begin
                    bank_en[{1'b1, elem, 1'b1}] = 1'b1;
                end
                word = addr[BOFF:4];
            end
        end
    end
endmodule

// File: rtl/tmac_clash.sv
module tmac_clash #(
    parameter int NPORT = 3,
    parameter int NBANK = 16
) (
    input  logic [NPORT-1:0][NBANK-1:0] want,
    output logic [NPORT-1:0]            clash
);
    for (genvar p = 0; p < NPORT; p++) begin : g_port
        logic [NBANK-1:0] others;
        always_comb begin
            others = '0;
            for (int q = 0; q < NPORT; q++) begin
                if (q != p) begin
                    others = others | want[q];
                end
            end
            clash[p] = |(want[p] & others);
        end
    end
endmodule

// File: rtl/tile_mem_access_chk.sv
module tile_mem_access_chk
    import tmac_pkg::*;
#(
    parameter int          ADDR_W     = 21,
    parameter int          REGION_BIT = 17,
    parameter int          BANK_BYTES = 16384,
    parameter int unsigned POP_BASE   = 32'h4_0000,
    parameter int unsigned POP_LAST   = 32'h7_FFFF,
    parameter int          NBANK      = 2 * ((1 << REGION_BIT) / BANK_BYTES),
    parameter int          WORD_W     = $clog2(BANK_BYTES / 8)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              if_valid,
    input  logic [ADDR_W-1:0] if_addr,
    input  logic              da_valid,
    input  logic [ADDR_W-1:0] da_addr,
    input  logic [2:0]        da_size,
    input  logic              da_wr,
    input  logic              db_valid,
    input  logic [ADDR_W-1:0] db_addr,
    input  logic [2:0]        db_size,
    input  logic              db_wr,
    output logic [NBANK-1:0]  if_bank_en,
    output logic [WORD_W-1:0] if_word,
    output logic [2:0]        if_exc,
    output logic [NBANK-1:0]  da_bank_en,
    output logic [WORD_W-1:0] da_word,
    output logic [2:0]        da_exc,
    output logic [NBANK-1:0]  db_bank_en,
    output logic [WORD_W-1:0] db_word,
    output logic [2:0]        db_exc
);
    localparam int NPORT = 3;

    typedef struct packed {
        logic [NPORT-1:0][NBANK-1:0]  en;
        logic [NPORT-1:0][WORD_W-1:0] word;
        logic [NPORT-1:0][2:0]        exc;
    } state_t;

    logic [NPORT-1:0]              p_valid;
    logic [NPORT-1:0]              p_fetch;
    logic [NPORT-1:0][ADDR_W-1:0]  p_addr;
    logic [NPORT-1:0][2:0]         p_size;
    logic [NPORT-1:0]              p_wr;
    logic [NPORT-1:0]              p_blk;
    logic [NPORT-1:0][NBANK-1:0]   pre_en;
    logic [NPORT-1:0][WORD_W-1:0]  pre_word;
    logic [NPORT-1:0][2:0]         pre_exc;
    logic [NPORT-1:0]              clash;
    state_t                        state_d;
    state_t                        state_q;

    // port 0 = fetch, 1 = data A, 2 = data B
    assign p_valid = {db_valid, da_valid, if_valid};
    assign p_fetch = 3'b001;
    assign p_addr  = {db_addr, da_addr, if_addr};
    assign p_size  = {db_size, da_size, SZ_64};
    assign p_wr    = {db_wr, da_wr, 1'b0};
    assign p_blk   = {da_valid & da_wr, 1'b0, 1'b0};

    for (genvar p = 0; p < NPORT; p++) begin : g_dec
        tmac_decode #(
            .ADDR_W    (ADDR_W),
            .REGION_BIT(REGION_BIT),
            .BANK_BYTES(BANK_BYTES),
            .POP_BASE  (POP_BASE),
            .POP_LAST  (POP_LAST),
            .NBANK     (NBANK),
            .WORD_W    (WORD_W)
        ) u_dec (
            .valid    (p_valid[p]),
            .is_fetch (p_fetch[p]),
            .addr     (p_addr[p]),
            .size     (p_size[p]),
            .wr       (p_wr[p]),
            .store_blk(p_blk[p]),
            .bank_en  (pre_en[p]),
            .word     (pre_word[p]),
            .exc      (pre_exc[p])
        );
    end

    tmac_clash #(
        .NPORT(NPORT),
        .NBANK(NBANK)
    ) u_clash (
        .want (pre_en),
        .clash(clash)
    );

    always_comb begin
        state_d = state_q;
        for (int p = 0; p < NPORT; p++) begin
            if ((pre_exc[p] == EXC_NONE) && clash[p]) begin
                state_d.exc[p]  = EXC_CLASH;
                state_d.en[p]   = '0;
                state_d.word[p] = '0;
            end else begin
                state_d.exc[p]  = pre_exc[p];
                state_d.en[p]   = pre_en[p];
                state_d.word[p] = pre_word[p];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign if_bank_en = state_q.en[0];
    assign if_word    = state_q.word[0];
    assign if_exc     = state_q.exc[0];
    assign da_bank_en = state_q.en[1];
    assign da_word    = state_q.word[1];
    assign da_exc     = state_q.exc[1];
    assign db_bank_en = state_q.en[2];
    assign db_word    = state_q.word[2];
    assign db_exc     = state_q.exc[2];
endmodule

// File: rtl/tmac_chk.sv
module tmac_chk #(
    parameter int          ADDR_W     = 21,
    parameter int          REGION_BIT = 17,
    parameter int unsigned POP_BASE   = 32'h4_0000,
    parameter int unsigned POP_LAST   = 32'h7_FFFF,
    parameter int          NBANK      = 16,
    parameter int          WORD_W     = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              if_valid,
    input logic [ADDR_W-1:0] if_addr,
    input logic              da_valid,
    input logic [ADDR_W-1:0] da_addr,
    input logic [2:0]        da_size,
    input logic              da_wr,
    input logic              db_valid,
    input logic [ADDR_W-1:0] db_addr,
    input logic [2:0]        db_size,
    input logic              db_wr,
    input logic [NBANK-1:0]  if_bank_en,
    input logic [WORD_W-1:0] if_word,
    input logic [2:0]        if_exc,
    input logic [NBANK-1:0]  da_bank_en,
    input logic [WORD_W-1:0] da_word,
    input logic [2:0]        da_exc,
    input logic [NBANK-1:0]  db_bank_en,
    input logic [WORD_W-1:0] db_word,
    input logic [2:0]        db_exc
);
    // R8
    disjoint_banks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((if_bank_en & da_bank_en) == '0) && ((if_bank_en & db_bank_en) == '0)
        && ((da_bank_en & db_bank_en) == '0));

    // R1
    unpop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (da_valid && ((32'(da_addr) < POP_BASE) || (32'(da_addr) > POP_LAST)))
        |=> (da_exc == 3'd1));

    // R5
    fetch_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(if_bank_en) && (if_bank_en[NBANK-1:NBANK/2] == '0));

    // R5
    fetch_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (if_valid && if_addr[REGION_BIT]) |=> (if_exc != 3'd0));

    // R4
    wide_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (da_valid && (da_size == 3'd4) && !da_addr[REGION_BIT]) |=> (da_exc != 3'd0));

    // R7
    dual_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (da_valid && da_wr && db_valid && db_wr) |=> (db_exc != 3'd0));

    // R10
    idle_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !db_valid |=> ((db_exc == 3'd0) && (db_bank_en == '0) && (db_word == '0)));

    // R4
    pair_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(da_bank_en) <= 2) && ($countones(db_bank_en) <= 2));

    // R11
    quiet_on_exc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (if_exc != 3'd0) |-> ((if_bank_en == '0) && (if_word == '0)));
endmodule

bind tile_mem_access_chk tmac_chk u_chk (.*);

// File: tb/tile_mem_access_chk_bench.sv
`timescale 1ns/1ps
module tile_mem_access_chk_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        if_valid = 1'b0;
    logic [20:0] if_addr = '0;
    logic        da_valid = 1'b0;
    logic [20:0] da_addr = '0;
    logic [2:0]  da_size = '0;
    logic        da_wr = 1'b0;
    logic        db_valid = 1'b0;
    logic [20:0] db_addr = '0;
    logic [2:0]  db_size = '0;
    logic        db_wr = 1'b0;
    logic [15:0] if_bank_en, da_bank_en, db_bank_en;
    logic [10:0] if_word, da_word, db_word;
    logic [2:0]  if_exc, da_exc, db_exc;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tile_mem_access_chk u_tile_mem_access_chk (.*);

    // Per-port expectation from the requirements (before clash).
    function automatic void model(input logic v, input logic f, input logic [20:0] a,
                                  input logic [2:0] sz, input logic wr, input logic sb,
                                  output logic [15:0] m, output logic [10:0] w,
                                  output logic [2:0] e);
        int ai, bytes, rg, bk;
        logic [2:0] s;
        ai = int'(a);
        s  = f ? 3'd3 : sz;
        m = '0; w = '0; e = 3'd0;
        if (!v) return;
        rg = (ai >> 17) & 1;
        bytes = (s <= 3'd4) ? (1 << s) : 1;
        if (ai < 'h40000 || ai > 'h7FFFF) e = 3'd1;                  // R1
        else if ((ai % bytes) != 0) e = 3'd2;                          // R6
        else if (f && rg == 1) e = 3'd3;                               // R5
        else if (!f && (sz > 3'd4 || (sz == 3'd4 && rg == 0))) e = 3'd3; // R4 R6
        else if (!f && wr && sz != 3'd2 && sz != 3'd3) e = 3'd3;       // R7
        else if (!f && wr && sb) e = 3'd3;                             // R7
        else if (rg == 0) begin                                        // R2
            bk = (ai >> 14) & 7;
            m[bk] = 1'b1;
            w = 11'((ai >> 3) & 2047);
        end else begin                                                 // R3
            bk = 8 + 2 * ((ai >> 15) & 3) + ((ai >> 3) & 1);
            m[bk] = 1'b1;
            if (sz == 3'd4 && !f) m[bk + 1] = 1'b1;
            w = 11'((ai >> 4) & 2047);
        end
    endfunction

    function automatic string tag_of(input bit f, input logic v, input logic [2:0] sz,
                                     input logic wr, input logic [20:0] a, input logic [2:0] e);
        if (!v) return "R10";
        case (e)
            3'd1: return "R1";
            3'd2: return f ? "R5" : "R6";
            3'd3: return f ? "R5" : (wr ? "R7" : (sz == 3'd4 ? "R4" : "R6"));
            3'd4: return "R8";
            default: return a[17] ? "R3" : "R2";
        endcase
    endfunction

    task automatic check_port(input string tag, input string pn,
                              input logic [15:0] ae, input logic [10:0] aw, input logic [2:0] ax,
                              input logic [15:0] ee, input logic [10:0] ew, input logic [2:0] ex);
        n_chk++;
        if (ae !== ee || aw !== ew || ax !== ex) begin
            n_bad++;
            $display("FAIL %s %s: actual en=%h word=%h exc=%0d expected en=%h word=%h exc=%0d",
                     tag, pn, ae, aw, ax, ee, ew, ex);
        end
        if (ex != 3'd0) begin
            n_chk++;
            if (ae !== '0 || aw !== '0) begin
                n_bad++;
                $display("FAIL R11 %s: actual en=%h word=%h expected en=0 word=0", pn, ae, aw);
            end
        end
    endtask

    // Apply current inputs for one clock, then compare (R10: one-cycle latency).
    task automatic step(input string force_tag);
        logic [2:0][15:0] m;
        logic [2:0][10:0] w;
        logic [2:0][2:0]  e;
        logic [15:0] oth;
        string t0, t1, t2;
        model(if_valid, 1'b1, if_addr, 3'd3, 1'b0, 1'b0, m[0], w[0], e[0]);
        model(da_valid, 1'b0, da_addr, da_size, da_wr, 1'b0, m[1], w[1], e[1]);
        model(db_valid, 1'b0, db_addr, db_size, db_wr, da_valid & da_wr, m[2], w[2], e[2]);
        begin : clash_blk // R8 R9: only error-free ports compete
            logic [2:0] hit;
            for (int p = 0; p < 3; p++) begin
                oth = '0;
                for (int q = 0; q < 3; q++) if (q != p) oth = oth | m[q];
                hit[p] = |(m[p] & oth);
            end
            for (int p = 0; p < 3; p++)
                if (hit[p]) begin m[p] = '0; w[p] = '0; e[p] = 3'd4; end
        end
        t0 = tag_of(1'b1, if_valid, 3'd3, 1'b0, if_addr, e[0]);
        t1 = tag_of(1'b0, da_valid, da_size, da_wr, da_addr, e[1]);
        t2 = tag_of(1'b0, db_valid, db_size, db_wr, db_addr, e[2]);
        if (force_tag != "") begin t0 = force_tag; t1 = force_tag; t2 = force_tag; end
        @(posedge clk);
        @(negedge clk);
        check_port(t0, "fetch", if_bank_en, if_word, if_exc, m[0], w[0], e[0]);
        check_port(t1, "dataA", da_bank_en, da_word, da_exc, m[1], w[1], e[1]);
        check_port(t2, "dataB", db_bank_en, db_word, db_exc, m[2], w[2], e[2]);
    endtask

    function automatic logic [20:0] choice_addr(input int c);
        if (c < 8)  return 21'('h40000 + c * 'h4000 + 'h18);
        if (c < 16) return 21'('h60000 + ((c - 8) >> 1) * 'h8000 + ((c - 8) & 1) * 8 + 'h20);
        if (c < 20) return 21'('h60000 + (c - 16) * 'h8000 + 'h30);
        case (c)
            20: return 21'h3FFF8;
            21: return 21'h40004;
            22: return 21'h44000;
            default: return 21'h80000;
        endcase
    endfunction

    function automatic logic [2:0] choice_size(input int c);
        return (c >= 16 && c < 20) || c == 22 ? 3'd4 : 3'd3;
    endfunction

    initial begin
        // R10: reset state with busy inputs
        if_valid = 1'b1; if_addr = 21'h40008;
        da_valid = 1'b1; da_addr = 21'h44000; da_size = 3'd3;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_port("R10", "fetch", if_bank_en, if_word, if_exc, '0, '0, '0);
        check_port("R10", "dataA", da_bank_en, da_word, da_exc, '0, '0, '0);
        check_port("R10", "dataB", db_bank_en, db_word, db_exc, '0, '0, '0);
        rst_n = 1'b1;
        if_valid = 1'b0; da_valid = 1'b0;

        // Data port A alone: addresses across both regions and edges, all sizes (R1-R4, R6, R7 tags per case)
        for (int a = 'h3F000; a <= 'h81000; a += 'h404) begin
            for (int s = 0; s < 8; s++) begin
                for (int wv = 0; wv < 2; wv++) begin
                    da_valid = 1'b1; da_addr = 21'(a); da_size = 3'(s); da_wr = wv[0];
                    step("");
                end
            end
        end
        da_valid = 1'b0; da_wr = 1'b0;

        // Fetch alone (R5): step of 0x102 hits misaligned and aligned addresses
        for (int a = 'h3F000; a <= 'h81000; a += 'h102) begin
            if_valid = 1'b1; if_addr = 21'(a);
            step("");
        end
        // Data port B alone at the odd/even boundary of a pair (R3)
        for (int a = 'h6FFE0; a < 'h70020; a += 8) begin
            db_valid = 1'b1; db_addr = 21'(a); db_size = 3'd3; db_wr = 1'b0;
            if_valid = 1'b0;
            step("");
        end

        // Three ports together: clash grid mixed with own exceptions (R8, R9)
        for (int fb = 0; fb < 8; fb++) begin
            for (int c0 = 0; c0 < 24; c0++) begin
                for (int c1 = 0; c1 < 24; c1++) begin
                    for (int wp = 0; wp < 3; wp++) begin
                        if_valid = 1'b1; if_addr = 21'('h40000 + fb * 'h4000 + fb * 8);
                        da_valid = 1'b1; da_addr = choice_addr(c0); da_size = choice_size(c0);
                        db_valid = 1'b1; db_addr = choice_addr(c1); db_size = choice_size(c1);
                        da_wr = (wp == 1); db_wr = (wp == 2);
                        step("");
                    end
                end
            end
        end

        // R7: two stores in one cycle on different banks
        if_valid = 1'b0;
        da_valid = 1'b1; da_addr = 21'h40000; da_size = 3'd3; da_wr = 1'b1;
        db_valid = 1'b1; db_addr = 21'h48000; db_size = 3'd2; db_wr = 1'b1;
        step("R7");

        // R9: priority directed cases
        if_valid = 1'b1; if_addr = 21'h60004;                 // misaligned beats illegal region
        da_valid = 1'b1; da_addr = 21'h3FFFC; da_size = 3'd3; da_wr = 1'b1; // unpop beats misalign
        db_valid = 1'b1; db_addr = 21'h40000; db_size = 3'd4; db_wr = 1'b0; // illegal, not clash
        step("R9");
        if_addr = 21'h40000;                                  // db illegal: fetch sees no clash
        da_valid = 1'b0; da_wr = 1'b0;
        step("R9");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual run still busy, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule